// File: doc/BRIEF.md
# Display Configuration Register Slave over SPI

This block lets a host processor program a small TFT display controller through a serial peripheral interface. The host sends frames of one address byte and one data byte. Bit 7 of the address byte sets the direction. For a write, the slave stores the data byte in an 8-bit register selected by the 7-bit address. For a read, the slave returns the addressed register on MISO during the second byte. Address 0 holds a fixed chip identifier. A write to the reset register with bit 0 cleared reloads every register with its default.

The stored codes are decoded into named control fields for the display logic downstream: power-control bits, scan directions, video standard, input format, sync polarities, sync mode, line inversion, and the eight pairs of gamma nybbles. SCLK, chip select and MOSI are sampled in the system clock domain through two-stage synchronisers, so SCLK must be slow compared with the system clock. The port set is the 4-wire one. A 3-wire host ties MOSI and MISO together outside the block during the read byte.

Top module: `cfg_spi_regfile`

## Requirements
- R1: A write frame is 16 SCLK rising edges while chip select is low, MSB first, SPI mode 0. The first byte is {1'b0, addr[6:0]} and the second is the data. The register takes the data on the system clock cycle after the edge that samples the last data bit.
- R2: A read frame sends {1'b1, addr[6:0]} as the first byte. During the next 8 SCLK cycles the slave drives the register value on MISO, MSB first. MISO changes after each falling edge and is valid at the rising edge. MISO is 0 outside the read byte.
- R3: Address 0x00 always reads 0x96, and writes to it change no register.
- R4: Writing a data byte with bit 0 = 0 to address 0x04 reloads every register with its default. Address 0x04 itself always reads 0x01.
- R5: Reset values (both after rst_n and after R4): 0x01=0x0F, 0x02=0x2E, 0x03=0x12, 0x06=0x0F, 0x07=0xEE, 0x08=0x00, 0x09=0x00, 0x0A=0x09, 0x0B=0x00, 0x10..0x17=0x00.
- R6: The implemented addresses are 0x00..0x04, 0x06..0x0B and 0x10..0x17. Every other address (0x05, 0x0C..0x0F, 0x18..0x7F) reads 0x00, and writes to it change no register.
- R7: Writable bit masks are 0x3F at 0x08, 0x7F at 0x0A and 0x0D at 0x0B. All other writable registers keep the full byte. Bits outside the mask read 0.
- R8: Entry register 0x06 drives the scan and format outputs: scan_hdir = bit 0, scan_vdir = bit 1, video_std = bits 3:2, input_fmt = bits 7:4.
- R9: Power register 0x07 drives the power outputs: pwr_normal = bit 0, pwr_supply_en = bits 5:1, pwr_auto = bit 6.
- R10: sync_pol = register 0x0A bits 6:0, sync_mode = register 0x0B bits 3:2, line_inv = register 0x0B bit 0.
- R11: For k = 0..7, gamma_neg[4k+3:4k] = register (0x10+k) bits 7:4, and gamma_pos[4k+3:4k] = bits 3:0.
- R12: Raising chip select before the 16th SCLK rising edge discards the frame and changes no register. The next frame decodes from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| pwr_normal | output | 1 | 1 = normal operation, 0 = standby |
| pwr_supply_en | output | 5 | Individual supply enables |
| pwr_auto | output | 1 | Automatic power sequencing |
| scan_hdir | output | 1 | 1 = left-to-right scan |
| scan_vdir | output | 1 | 1 = top-to-bottom scan |
| video_std | output | 2 | 0 NTSC, 1 PAL, 3 autodetect |
| input_fmt | output | 4 | Input format code |
| sync_pol | output | 7 | Clock, sync, enable polarities and colour order flags |
| sync_mode | output | 2 | Sync signal usage mode |
| line_inv | output | 1 | 1 = line inversion, 0 = frame inversion |
| gamma_neg | output | 32 | Eight negative gamma nybbles |
| gamma_pos | output | 32 | Eight positive gamma nybbles |

## Verification
The bench targets the corner cases of this block:
- A slave that misdecodes the direction bit would store read frames as writes or return data for write frames.
- A slave that lets the identifier address or an unimplemented address be written, or that aliases addresses above 0x44 onto real registers, would read back a nonzero or changed byte.
- A global reset that misses a register, or that fires when bit 0 is set, would leave a stale field or wipe the configuration.
- Frames cut short by chip select must leave every register alone. A counter that is not cleared would shift the next frame's address by some bits.

// File: rtl/cfgspi_pkg.sv
`timescale 1ns/1ps
package cfgspi_pkg;
  localparam int          ADDR_W     = 7;
  localparam int          DATA_W     = 8;
  localparam int          LAST_ADDR  = 68;
  localparam int          N_GAMMA    = 8;
  localparam int          GAMMA_BASE = 16;
  localparam int          ENTRY_ADDR = 6;
  localparam int          PWR_ADDR   = 7;
  localparam int          POL_ADDR   = 10;
  localparam int          IFC_ADDR   = 11;
  localparam int          GRES_ADDR  = 4;
  localparam logic [7:0]  CHIP_ID    = 8'h96;

  function automatic logic reg_impl(input logic [ADDR_W-1:0] a);
    return (a <= 7'd4) || (a >= 7'd6 && a <= 7'd11) ||
           (a >= 7'(GAMMA_BASE) && a < 7'(GAMMA_BASE + N_GAMMA));
  endfunction

  function automatic logic [7:0] reg_default(input logic [ADDR_W-1:0] a);
    case (a)
      7'd0:    return CHIP_ID;
      7'd1:    return 8'h0F;
      7'd2:    return 8'h2E;
      7'd3:    return 8'h12;
      7'd4:    return 8'h01;
      7'd6:    return 8'h0F;
      7'd7:    return 8'hEE;
      7'd10:   return 8'h09;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_wmask(input logic [ADDR_W-1:0] a);
    case (a)
      7'd4:    return 8'h01;
      7'd8:    return 8'h3F;
      7'd10:   return 8'h7F;
      7'd11:   return 8'h0D;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic is_gres(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    return (a == 7'(GRES_ADDR)) && !d[0];
  endfunction
endpackage

// File: rtl/bit_sync.sv
`timescale 1ns/1ps
module bit_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_frame_rx.sv
`timescale 1ns/1ps
module spi_frame_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  output logic              wr_pulse,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data
);
  localparam int FRAME_BITS = 2 * DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  logic sclk_s, cs_s, mosi_s, sclk_d;
  logic sclk_rise, sclk_fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] sh, next_byte, tx_sh;
  logic              is_read, miso_q;
  logic [ADDR_W-1:0] addr_q;

  bit_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sclk, cs_n, mosi}), .q({sclk_s, cs_s, mosi_s})
  );

  assign sclk_rise = sclk_s & ~sclk_d & ~cs_s;
  assign sclk_fall = ~sclk_s & sclk_d & ~cs_s;
  assign next_byte = {sh[DATA_W-2:0], mosi_s};
  assign rd_addr   = next_byte[ADDR_W-1:0];
  assign wr_addr   = addr_q;
  assign miso      = miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      bit_cnt  <= '0;
      sh       <= '0;
      tx_sh    <= '0;
      is_read  <= 1'b0;
      addr_q   <= '0;
      wr_data  <= '0;
      wr_pulse <= 1'b0;
      miso_q   <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      wr_pulse <= 1'b0;
      if (cs_s) begin
        bit_cnt <= '0;
        tx_sh   <= '0;
        miso_q  <= 1'b0;
      end else begin
        if (sclk_rise && bit_cnt < CNT_W'(FRAME_BITS)) begin
          sh      <= next_byte;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(DATA_W - 1)) begin
            is_read <= next_byte[DATA_W-1];
            addr_q  <= next_byte[ADDR_W-1:0];
            if (next_byte[DATA_W-1]) tx_sh <= rd_data;
          end
          if (bit_cnt == CNT_W'(FRAME_BITS - 1) && !is_read) begin
            wr_pulse <= 1'b1;
            wr_data  <= next_byte;
          end
        end
        if (sclk_fall) begin
          miso_q <= tx_sh[DATA_W-1];
          tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  a_r1_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_BITS));
  a_r12_cs_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bit_cnt == '0));
endmodule

// File: rtl/cfg_regfile.sv
`timescale 1ns/1ps
module cfg_regfile #(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int LAST_ADDR = 68
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_pulse,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic [ADDR_W-1:0]                rd_addr,
  output logic [DATA_W-1:0]                rd_data,
  output logic [DATA_W*(LAST_ADDR+1)-1:0]  regs_flat
);
  import cfgspi_pkg::*;

  logic gres;
  assign gres = wr_pulse && is_gres(wr_addr, wr_data);

  for (genvar i = 0; i <= LAST_ADDR; i++) begin : g_reg
    if (i == 0) begin : g_id
      assign regs_flat[i*DATA_W +: DATA_W] = CHIP_ID;
    end else if (reg_impl(ADDR_W'(i))) begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= reg_default(ADDR_W'(i));
        else if (gres)
          q <= reg_default(ADDR_W'(i));
        else if (wr_pulse && wr_addr == ADDR_W'(i))
          q <= wr_data & reg_wmask(ADDR_W'(i));
      end
      assign regs_flat[i*DATA_W +: DATA_W] = q;
    end else begin : g_none
      assign regs_flat[i*DATA_W +: DATA_W] = '0;
    end
  end

  always_comb begin
    if (int'(rd_addr) <= LAST_ADDR)
      rd_data = regs_flat[int'(rd_addr)*DATA_W +: DATA_W];
    else
      rd_data = '0;
  end

  a_r4_gres_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    gres |=> (regs_flat[1*DATA_W +: DATA_W] == 8'h0F &&
              regs_flat[2*DATA_W +: DATA_W] == 8'h2E &&
              regs_flat[3*DATA_W +: DATA_W] == 8'h12));
  a_r6_unimpl_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && !reg_impl(wr_addr)) |=> $stable(regs_flat));
  a_r3_id_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && wr_addr == '0) |=> $stable(regs_flat));
  a_r1_pwr_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && wr_addr == ADDR_W'(PWR_ADDR)) |=>
      (regs_flat[PWR_ADDR*DATA_W +: DATA_W] == $past(wr_data)));
endmodule

// File: rtl/cfg_spi_regfile.sv
`timescale 1ns/1ps
module cfg_spi_regfile #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        pwr_normal,
  output logic [4:0]  pwr_supply_en,
  output logic        pwr_auto,
  output logic        scan_hdir,
  output logic        scan_vdir,
  output logic [1:0]  video_std,
  output logic [3:0]  input_fmt,
  output logic [6:0]  sync_pol,
  output logic [1:0]  sync_mode,
  output logic        line_inv,
  output logic [cfgspi_pkg::N_GAMMA*4-1:0] gamma_neg,
  output logic [cfgspi_pkg::N_GAMMA*4-1:0] gamma_pos
);
  import cfgspi_pkg::*;
  localparam int FLAT_W = DATA_W * (LAST_ADDR + 1);

  logic              wr_pulse;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [FLAT_W-1:0] regs_flat;
  logic [DATA_W-1:0] entry_q, pwr_q, pol_q, ifc_q;

  spi_frame_rx #(.SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso),
    .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  cfg_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAST_ADDR(LAST_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .regs_flat(regs_flat)
  );

  assign entry_q = regs_flat[ENTRY_ADDR*DATA_W +: DATA_W];
  assign pwr_q   = regs_flat[PWR_ADDR*DATA_W +: DATA_W];
  assign pol_q   = regs_flat[POL_ADDR*DATA_W +: DATA_W];
  assign ifc_q   = regs_flat[IFC_ADDR*DATA_W +: DATA_W];

  assign scan_hdir     = entry_q[0];
  assign scan_vdir     = entry_q[1];
  assign video_std     = entry_q[3:2];
  assign input_fmt     = entry_q[7:4];
  assign pwr_normal    = pwr_q[0];
  assign pwr_supply_en = pwr_q[5:1];
  assign pwr_auto      = pwr_q[6];
  assign sync_pol      = pol_q[6:0];
  assign sync_mode     = ifc_q[3:2];
  assign line_inv      = ifc_q[0];

  for (genvar k = 0; k < N_GAMMA; k++) begin : g_gamma
    assign gamma_pos[k*4 +: 4] = regs_flat[(GAMMA_BASE+k)*DATA_W +: 4];
    assign gamma_neg[k*4 +: 4] = regs_flat[(GAMMA_BASE+k)*DATA_W + 4 +: 4];
  end

  logic unused_bits;
  assign unused_bits = ^{regs_flat, pwr_q[7], pol_q[7], ifc_q[1], ifc_q[7:4]};
endmodule

// File: tb/cfg_spi_regfile_test.sv
`timescale 1ns/1ps
module cfg_spi_regfile_test;
  logic clk = 0, rst_n = 0;
  logic spi_sclk = 0, spi_cs_n = 1, spi_mosi = 0;
  logic spi_miso, pwr_normal, pwr_auto, scan_hdir, scan_vdir, line_inv;
  logic [4:0] pwr_supply_en;
  logic [1:0] video_std, sync_mode;
  logic [3:0] input_fmt;
  logic [6:0] sync_pol;
  logic [31:0] gamma_neg, gamma_pos;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q [0:127];

  always #5 clk = ~clk;

  cfg_spi_regfile uut (.*);

  function automatic bit b_impl(input int a);
    return (a >= 0 && a <= 4) || (a >= 6 && a <= 11) || (a >= 16 && a <= 23);
  endfunction
  function automatic logic [7:0] b_def(input int a);
    if (!b_impl(a)) return 8'h00;
    case (a)
      0: return 8'h96;  1: return 8'h0F;  2: return 8'h2E;  3: return 8'h12;
      4: return 8'h01;  6: return 8'h0F;  7: return 8'hEE; 10: return 8'h09;
      default: return 8'h00;
    endcase
  endfunction
  function automatic logic [7:0] b_mask(input int a);
    case (a)
      4: return 8'h01;  8: return 8'h3F; 10: return 8'h7F; 11: return 8'h0D;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic model_reset();
    for (int a = 0; a < 128; a++) exp_q[a] = b_def(a);
  endtask
  task automatic model_write(input int a, input logic [7:0] d);
    if (a == 4 && !d[0]) model_reset();
    else if (b_impl(a) && a != 0) exp_q[a] = d & b_mask(a);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic frame(input logic [15:0] bits, input int n, output logic [7:0] rx);
    rx = '0;
    spi_cs_n = 0; wait_clk(8);
    for (int i = 0; i < n; i++) begin
      spi_mosi = bits[15-i]; wait_clk(8);
      if (i >= 8) rx = {rx[6:0], spi_miso};
      spi_sclk = 1; wait_clk(8);
      spi_sclk = 0;
    end
    wait_clk(8); spi_cs_n = 1; spi_mosi = 0; wait_clk(12);
  endtask

  task automatic spi_write(input int a, input logic [7:0] d);
    logic [7:0] junk;
    frame({1'b0, 7'(a), d}, 16, junk);
    model_write(a, d);
  endtask
  task automatic spi_read(input int a, output logic [7:0] d);
    frame({1'b1, 7'(a), 8'h00}, 16, d);
  endtask
  task automatic read_chk(input string tag, input int a);
    logic [7:0] d;
    spi_read(a, d);
    chk(tag, {24'h0, d}, {24'h0, exp_q[a]});
  endtask

  task automatic fields_chk(input string ctx);
    chk({ctx, " R8 scan_hdir"}, {31'h0, scan_hdir}, {31'h0, exp_q[6][0]});
    chk({ctx, " R8 scan_vdir"}, {31'h0, scan_vdir}, {31'h0, exp_q[6][1]});
    chk({ctx, " R8 video_std"}, {30'h0, video_std}, {30'h0, exp_q[6][3:2]});
    chk({ctx, " R8 input_fmt"}, {28'h0, input_fmt}, {28'h0, exp_q[6][7:4]});
    chk({ctx, " R9 power"}, {25'h0, pwr_auto, pwr_supply_en, pwr_normal}, {25'h0, exp_q[7][6:0]});
    chk({ctx, " R10 sync_pol"}, {25'h0, sync_pol}, {25'h0, exp_q[10][6:0]});
    chk({ctx, " R10 sync_mode/line_inv"}, {29'h0, sync_mode, line_inv},
        {29'h0, exp_q[11][3:2], exp_q[11][0]});
    for (int k = 0; k < 8; k++) begin
      chk({ctx, " R11 gamma_pos"}, {28'h0, gamma_pos[k*4 +: 4]}, {28'h0, exp_q[16+k][3:0]});
      chk({ctx, " R11 gamma_neg"}, {28'h0, gamma_neg[k*4 +: 4]}, {28'h0, exp_q[16+k][7:4]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240611));
    model_reset();
    wait_clk(5); rst_n = 1; wait_clk(5);

    // R5 reset state on outputs and by read-back
    fields_chk("reset R5");
    for (int a = 0; a < 24; a++) read_chk("R5 R6 reset readback", a);

    // R3 identifier read-only
    spi_write(0, 8'h00);
    read_chk("R3 id after write", 0);
    chk("R3 id value", {24'h0, exp_q[0]}, 32'h96);

    // R1 R9 writes and decode
    spi_write(7, 8'h5B);
    fields_chk("R1 R9 power write");
    read_chk("R2 read power", 7);
    spi_write(6, 8'hB4);
    fields_chk("R8 entry write");

    // R7 masks
    spi_write(8, 8'hFF);  read_chk("R7 mask 0x08", 8);
    spi_write(10, 8'hFF); read_chk("R7 mask 0x0A", 10);
    spi_write(11, 8'hFF); read_chk("R7 mask 0x0B", 11);
    spi_write(4, 8'hFF);  read_chk("R4 reset reg reads 01", 4);
    fields_chk("R10 after masks");

    // R6 boundary addresses
    spi_write(5, 8'hA5);   read_chk("R6 addr 0x05", 5);
    spi_write(68, 8'h77);  read_chk("R6 addr 0x44", 68);
    spi_write(69, 8'h77);  read_chk("R6 addr 0x45", 69);
    spi_write(127, 8'hFF); read_chk("R6 addr 0x7F", 127);
    read_chk("R6 neighbour 0x17 untouched", 23);

    // R11 gamma
    for (int k = 0; k < 8; k++) spi_write(16 + k, 8'(8'h1F * (k + 1)));
    fields_chk("R11 gamma");

    // R12 abort mid-frame, then a clean frame
    frame({1'b0, 7'd7, 8'h00}, 12, d);
    read_chk("R12 abort keeps 0x07", 7);
    frame({1'b0, 7'd1, 8'h00}, 5, d);
    spi_write(2, 8'h3C);
    read_chk("R12 next frame aligned", 2);
    read_chk("R12 0x01 untouched", 1);

    // R4 global reset
    spi_write(4, 8'hFE);
    fields_chk("R4 after global reset");
    for (int a = 1; a < 24; a++) read_chk("R4 R5 defaults", a);

    // random mix
    for (int it = 0; it < 120; it++) begin
      int a;
      logic [7:0] v;
      a = int'($urandom_range(0, 72));
      v = 8'($urandom);
      if (a == 4 && ($urandom_range(0, 3) != 0)) v[0] = 1'b1;
      if ($urandom_range(0, 9) == 0) begin
        frame({1'b0, 7'(a), v}, int'($urandom_range(1, 15)), d);
      end else begin
        spi_write(a, v);
      end
      read_chk("R1 R2 R6 random readback", int'($urandom_range(0, 72)));
      if (it % 20 == 0) fields_chk("random R8 R9 R10 R11");
    end
    fields_chk("final");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule